// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Checker

This block sits between the instruction queue and the two integer pipes of an in-order, two-pipe superscalar front end. Each cycle it examines the two oldest decoded instructions, called slot 0 (older) and slot 1 (younger). It decides whether slot 0 issues alone or whether both issue together, one to each pipe. The decision depends on the class of each instruction, on the order of the two, and on register dependencies between them. The block returns a take count to the queue in the same cycle. The issue-valid and class outputs for both pipes are registered and appear one clock later.

A complex, microcoded instruction always issues alone. It then puts both pipes into microcode mode, and nothing else issues until the external sequencer reports completion on a done input. A request to return a 64-bit floating-point result over both pipes also blocks issue for that cycle.

Class encoding on the 3-bit class inputs:
- 0 = simple integer
- 1 = complex/microcoded
- 2 = branch
- 3 = floating-point
- 4 = FP register exchange

Codes 5 to 7 never pair.

Top module: `dual_issue_pairer`

## Requirements
- R1: Two simple integer instructions (class 0, class 0) with no register hazard issue together: take count 2 in that cycle, and in the next cycle both `pipe_u_vld` and `pipe_v_vld` are 1.
- R2: A simple integer in slot 0 followed by a branch (class 2) in slot 1, with no hazard, issues as a pair with take count 2.
- R3: A branch in slot 0 never pairs. The take count is 1 whatever occupies slot 1, and in the next cycle only `pipe_u_vld` is 1.
- R4: Two FP-type instructions (classes 3 and 4) pair only when at least one of them is the exchange (class 4), in either order. Two ordinary FP instructions (3, 3) issue singly.
- R5: A complex instruction (class 1) issues alone, with take count 1. From the next cycle `mc_active` is 1, and while it stays 1 the take count is 0 and no pipe-valid output rises. A cycle in which `mc_done` is 1 clears `mc_active` at the following edge, and issue resumes in the cycle after that.
- R6: A complex instruction in either slot prevents pairing, so only one complex instruction can be in flight.
- R7: If slot 0 writes a register (`s0_wr` = 1) that slot 1 reads through either source or also writes, the pair is refused and the take count is 1. With `s0_wr` = 0 the same register numbers do not block pairing.
- R8: An invalid slot 1 forces single issue, and a mixed integer/FP pair never issues together.
- R9: While `wb64_req` is 1 the take count is 0, and in the next cycle both pipe-valid outputs are 0.
- R10: When slot 0 is invalid the take count is 0.
- R11: A synchronous active-high reset clears `mc_active`, `pipe_u_vld` and `pipe_v_vld` at the next clock edge.
- R12: The registered class outputs carry the class of the instruction issued to that pipe: slot 0 goes to pipe U and slot 1 to pipe V. `pipe_v_vld` is never 1 without `pipe_u_vld`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s0_vld | input | 1 | Slot 0 holds an instruction |
| s0_cls | input | 3 | Slot 0 class code |
| s0_dst | input | REG_W | Slot 0 destination register |
| s0_wr | input | 1 | Slot 0 writes its destination |
| s0_srca | input | REG_W | Slot 0 first source register |
| s0_srcb | input | REG_W | Slot 0 second source register |
| s1_vld | input | 1 | Slot 1 holds an instruction |
| s1_cls | input | 3 | Slot 1 class code |
| s1_dst | input | REG_W | Slot 1 destination register |
| s1_wr | input | 1 | Slot 1 writes its destination |
| s1_srca | input | REG_W | Slot 1 first source register |
| s1_srcb | input | REG_W | Slot 1 second source register |
| mc_done | input | 1 | Microcode sequencer reports completion |
| wb64_req | input | 1 | 64-bit FP result needs both pipes this cycle |
| take_cnt | output | 2 | Instructions consumed from the queue this cycle |
| pipe_u_vld | output | 1 | Pipe U received an instruction (registered) |
| pipe_u_cls | output | 3 | Class issued to pipe U (registered) |
| pipe_v_vld | output | 1 | Pipe V received an instruction (registered) |
| pipe_v_cls | output | 3 | Class issued to pipe V (registered) |
| mc_active | output | 1 | Both pipes are in microcode mode |

## Verification
The only state is the microcode-busy flag plus the two issue registers, so every internal fault surfaces within one clock. A busy flag stuck high shows as a take count of 0 in the very cycle after completion should have freed it. A flag that fails to set shows as a nonzero take count in the cycle right after a complex issue. A wrong pairing rule shows immediately on the combinational take count, and one edge later as a mismatched `pipe_v_vld` or class.

// File: rtl/dip_pkg.sv
package dip_pkg;

  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CL_INT  = 3'd0,
    CL_CPLX = 3'd1,
    CL_BR   = 3'd2,
    CL_FP   = 3'd3,
    CL_FXCH = 3'd4
  } iclass_e;

  function automatic logic is_fp_kind(input logic [CLS_W-1:0] c);
    return (c == CL_FP) || (c == CL_FXCH);
  endfunction

  // Order-sensitive class compatibility: a = older slot, b = younger slot.
  function automatic logic class_pair_ok(input logic [CLS_W-1:0] a,
                                         input logic [CLS_W-1:0] b);
    logic ok;
    ok = 1'b0;
    if (a == CL_INT && (b == CL_INT || b == CL_BR)) ok = 1'b1;
    if (is_fp_kind(a) && is_fp_kind(b) && (a == CL_FXCH || b == CL_FXCH)) ok = 1'b1;
    return ok;
  endfunction

  function automatic logic [1:0] take_count(input logic can_go, input logic two);
    if (!can_go) return 2'd0;
    return two ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/dip_pair_rules.sv
module dip_pair_rules
  import dip_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             s0_vld,
  input  logic [CLS_W-1:0] s0_cls,
  input  logic [REG_W-1:0] s0_dst,
  input  logic             s0_wr,
  input  logic             s1_vld,
  input  logic [CLS_W-1:0] s1_cls,
  input  logic [REG_W-1:0] s1_dst,
  input  logic             s1_wr,
  input  logic [REG_W-1:0] s1_srca,
  input  logic [REG_W-1:0] s1_srcb,
  output logic             cls_ok,
  output logic             hazard,
  output logic             pair_ok
);

  logic raw_hit;
  logic waw_hit;

  always_comb begin
    raw_hit = s0_wr && ((s1_srca == s0_dst) || (s1_srcb == s0_dst));
    waw_hit = s0_wr && s1_wr && (s1_dst == s0_dst);
    hazard  = raw_hit || waw_hit;
    cls_ok  = class_pair_ok(s0_cls, s1_cls);
    pair_ok = s0_vld && s1_vld && cls_ok && !hazard;
  end

endmodule

// File: rtl/dip_mc_tracker.sv
module dip_mc_tracker (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic done,
  output logic busy
);

  always_ff @(posedge clk) begin
    if (rst)
      busy <= 1'b0;
    else if (start)
      busy <= 1'b1;
    else if (busy && done)
      busy <= 1'b0;
  end

endmodule

// File: rtl/dip_issue_ctrl.sv
module dip_issue_ctrl
  import dip_pkg::*;
(
  input  logic             s0_vld,
  input  logic [CLS_W-1:0] s0_cls,
  input  logic             pair_ok,
  input  logic             mc_busy,
  input  logic             wb64_req,
  output logic             issue_one,
  output logic             issue_two,
  output logic             mc_start,
  output logic [1:0]       take_cnt
);

  always_comb begin
    issue_one = s0_vld && !mc_busy && !wb64_req;
    issue_two = issue_one && pair_ok;
    mc_start  = issue_one && (s0_cls == CL_CPLX);
    take_cnt  = take_count(issue_one, issue_two);
  end

endmodule

// File: rtl/dip_issue_regs.sv
module dip_issue_regs
  import dip_pkg::*;
#(
  parameter int NUM_PIPES = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_PIPES-1:0]            lane_go,
  input  logic [NUM_PIPES-1:0][CLS_W-1:0] lane_cls,
  output logic [NUM_PIPES-1:0]            lane_vld_q,
  output logic [NUM_PIPES-1:0][CLS_W-1:0] lane_cls_q
);

  for (genvar g = 0; g < NUM_PIPES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_vld_q[g] <= 1'b0;
        lane_cls_q[g] <= '0;
      end else begin
        lane_vld_q[g] <= lane_go[g];
        if (lane_go[g]) lane_cls_q[g] <= lane_cls[g];
      end
    end
  end

endmodule

// File: rtl/dual_issue_pairer.sv
module dual_issue_pairer
  import dip_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s0_vld,
  input  logic [2:0]       s0_cls,
  input  logic [REG_W-1:0] s0_dst,
  input  logic             s0_wr,
  input  logic [REG_W-1:0] s0_srca,
  input  logic [REG_W-1:0] s0_srcb,
  input  logic             s1_vld,
  input  logic [2:0]       s1_cls,
  input  logic [REG_W-1:0] s1_dst,
  input  logic             s1_wr,
  input  logic [REG_W-1:0] s1_srca,
  input  logic [REG_W-1:0] s1_srcb,
  input  logic             mc_done,
  input  logic             wb64_req,
  output logic [1:0]       take_cnt,
  output logic             pipe_u_vld,
  output logic [2:0]       pipe_u_cls,
  output logic             pipe_v_vld,
  output logic [2:0]       pipe_v_cls,
  output logic             mc_active
);

  localparam int NUM_PIPES = 2;

  // Named internal events, visible to the bound checker.
  logic cls_ok;
  logic hazard;
  logic pair_ok;
  logic issue_one;
  logic issue_two;
  logic mc_start;
  logic mc_busy;

  logic [NUM_PIPES-1:0]            lane_go;
  logic [NUM_PIPES-1:0][CLS_W-1:0] lane_cls;
  logic [NUM_PIPES-1:0]            lane_vld_q;
  logic [NUM_PIPES-1:0][CLS_W-1:0] lane_cls_q;

  // Slot 0 source registers matter only to older instructions already
  // in flight, which this stage does not track.
  logic unused_s0_src;
  assign unused_s0_src = ^{s0_srca, s0_srcb};

  dip_pair_rules #(.REG_W(REG_W)) u_rules (
    .s0_vld (s0_vld),
    .s0_cls (s0_cls),
    .s0_dst (s0_dst),
    .s0_wr  (s0_wr),
    .s1_vld (s1_vld),
    .s1_cls (s1_cls),
    .s1_dst (s1_dst),
    .s1_wr  (s1_wr),
    .s1_srca(s1_srca),
    .s1_srcb(s1_srcb),
    .cls_ok (cls_ok),
    .hazard (hazard),
    .pair_ok(pair_ok)
  );

  dip_issue_ctrl u_ctrl (
    .s0_vld   (s0_vld),
    .s0_cls   (s0_cls),
    .pair_ok  (pair_ok),
    .mc_busy  (mc_busy),
    .wb64_req (wb64_req),
    .issue_one(issue_one),
    .issue_two(issue_two),
    .mc_start (mc_start),
    .take_cnt (take_cnt)
  );

  dip_mc_tracker u_mc (
    .clk  (clk),
    .rst  (rst),
    .start(mc_start),
    .done (mc_done),
    .busy (mc_busy)
  );

  assign lane_go  = {issue_two, issue_one};
  assign lane_cls = {s1_cls, s0_cls};

  dip_issue_regs #(.NUM_PIPES(NUM_PIPES)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .lane_go   (lane_go),
    .lane_cls  (lane_cls),
    .lane_vld_q(lane_vld_q),
    .lane_cls_q(lane_cls_q)
  );

  assign pipe_u_vld = lane_vld_q[0];
  assign pipe_u_cls = lane_cls_q[0];
  assign pipe_v_vld = lane_vld_q[1];
  assign pipe_v_cls = lane_cls_q[1];
  assign mc_active  = mc_busy;

endmodule

// File: rtl/dual_issue_pairer_chk.sv
module dual_issue_pairer_chk (
  input logic       clk,
  input logic       rst,
  input logic       s0_vld,
  input logic [2:0] s0_cls,
  input logic       s1_vld,
  input logic [2:0] s1_cls,
  input logic       mc_done,
  input logic       wb64_req,
  input logic [1:0] take_cnt,
  input logic       pipe_u_vld,
  input logic       pipe_v_vld,
  input logic       mc_active,
  input logic       hazard
);

  a_r5_busy_blocks: assert property (@(posedge clk) disable iff (rst)
    mc_active |-> take_cnt == 2'd0);

  a_r5_complex_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (take_cnt != 2'd0 && s0_cls == 3'd1) |=> mc_active);

  a_r5_done_clears: assert property (@(posedge clk) disable iff (rst)
    (mc_active && mc_done) |=> !mc_active);

  a_r3_branch_first_alone: assert property (@(posedge clk) disable iff (rst)
    (s0_vld && s0_cls == 3'd2) |-> take_cnt != 2'd2);

  a_r6_complex_never_pairs: assert property (@(posedge clk) disable iff (rst)
    (s0_cls == 3'd1 || s1_cls == 3'd1) |-> take_cnt != 2'd2);

  a_r7_hazard_single: assert property (@(posedge clk) disable iff (rst)
    hazard |-> take_cnt != 2'd2);

  a_r8_slot1_empty_single: assert property (@(posedge clk) disable iff (rst)
    !s1_vld |-> take_cnt != 2'd2);

  a_r9_wb64_blocks: assert property (@(posedge clk) disable iff (rst)
    wb64_req |-> take_cnt == 2'd0);

  a_r10_empty_no_take: assert property (@(posedge clk) disable iff (rst)
    !s0_vld |-> take_cnt == 2'd0);

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!mc_active && !pipe_u_vld && !pipe_v_vld));

  a_r12_v_needs_u: assert property (@(posedge clk) disable iff (rst)
    pipe_v_vld |-> pipe_u_vld);

  a_r12_u_follows_take: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pipe_u_vld == ($past(take_cnt) != 2'd0));

  a_r12_v_follows_take: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pipe_v_vld == ($past(take_cnt) == 2'd2));

  always_comb begin
    a_r1_take_range: assert (take_cnt != 2'd3);
  end

endmodule

bind dual_issue_pairer dual_issue_pairer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .s0_vld    (s0_vld),
  .s0_cls    (s0_cls),
  .s1_vld    (s1_vld),
  .s1_cls    (s1_cls),
  .mc_done   (mc_done),
  .wb64_req  (wb64_req),
  .take_cnt  (take_cnt),
  .pipe_u_vld(pipe_u_vld),
  .pipe_v_vld(pipe_v_vld),
  .mc_active (mc_active),
  .hazard    (hazard)
);

// File: tb/dual_issue_pairer_tb_top.sv
module dual_issue_pairer_tb_top;

  localparam int RW = 5;
  localparam logic [2:0] C_INT = 3'd0, C_CPX = 3'd1, C_BR = 3'd2,
                         C_FP = 3'd3, C_FX = 3'd4;

  logic clk = 1'b0;
  logic rst;
  logic s0_vld, s0_wr, s1_vld, s1_wr;
  logic [2:0] s0_cls, s1_cls;
  logic [RW-1:0] s0_dst, s0_srca, s0_srcb, s1_dst, s1_srca, s1_srcb;
  logic mc_done, wb64_req;
  logic [1:0] take_cnt;
  logic pipe_u_vld, pipe_v_vld, mc_active;
  logic [2:0] pipe_u_cls, pipe_v_cls;

  int n_checks = 0;
  int n_errors = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  dual_issue_pairer #(.REG_W(RW)) dut_i (
    .clk(clk), .rst(rst),
    .s0_vld(s0_vld), .s0_cls(s0_cls), .s0_dst(s0_dst), .s0_wr(s0_wr),
    .s0_srca(s0_srca), .s0_srcb(s0_srcb),
    .s1_vld(s1_vld), .s1_cls(s1_cls), .s1_dst(s1_dst), .s1_wr(s1_wr),
    .s1_srca(s1_srca), .s1_srcb(s1_srcb),
    .mc_done(mc_done), .wb64_req(wb64_req),
    .take_cnt(take_cnt),
    .pipe_u_vld(pipe_u_vld), .pipe_u_cls(pipe_u_cls),
    .pipe_v_vld(pipe_v_vld), .pipe_v_cls(pipe_v_cls),
    .mc_active(mc_active)
  );

  task automatic check(input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Registers default to non-overlapping numbers: slot 0 writes r1,
  // slot 1 reads r4/r5 and writes r6.
  task automatic load(input logic v0, input logic [2:0] c0,
                      input logic v1, input logic [2:0] c1);
    s0_vld = v0; s0_cls = c0; s0_dst = 5'd1; s0_wr = 1'b1;
    s0_srca = 5'd2; s0_srcb = 5'd3;
    s1_vld = v1; s1_cls = c1; s1_dst = 5'd6; s1_wr = 1'b1;
    s1_srca = 5'd4; s1_srcb = 5'd5;
  endtask

  // Inputs already applied at a negedge: check take now, then the
  // registered outputs at the next negedge.
  task automatic step(input string req, input int exp_take,
                      input int exp_u, input int exp_v,
                      input int exp_ucls, input int exp_vcls, input int exp_mc);
    #1;
    check(req, "take_cnt", take_cnt, exp_take);
    @(posedge clk);
    @(negedge clk);
    check(req, "pipe_u_vld", pipe_u_vld, exp_u);
    check(req, "pipe_v_vld", pipe_v_vld, exp_v);
    if (exp_u != 0) check(req, "pipe_u_cls", pipe_u_cls, exp_ucls);
    if (exp_v != 0) check(req, "pipe_v_cls", pipe_v_cls, exp_vcls);
    check(req, "mc_active", mc_active, exp_mc);
  endtask

  task automatic t_reset();
    rst = 1'b1; mc_done = 1'b0; wb64_req = 1'b0;
    load(1'b0, C_INT, 1'b0, C_INT);
    repeat (2) @(negedge clk);
    check("R11", "mc_active after reset", mc_active, 0);
    check("R11", "pipe_u_vld after reset", pipe_u_vld, 0);
    check("R11", "pipe_v_vld after reset", pipe_v_vld, 0);
    rst = 1'b0;
  endtask

  task automatic t_int_pairs();
    load(1'b1, C_INT, 1'b1, C_INT);
    step("R1", 2, 1, 1, C_INT, C_INT, 0);
    load(1'b1, C_INT, 1'b1, C_BR);
    step("R2", 2, 1, 1, C_INT, C_BR, 0);
    load(1'b1, C_BR, 1'b1, C_INT);
    step("R3", 1, 1, 0, C_BR, 0, 0);
    load(1'b1, C_BR, 1'b1, C_BR);
    step("R3", 1, 1, 0, C_BR, 0, 0);
  endtask

  task automatic t_fp_pairs();
    load(1'b1, C_FP, 1'b1, C_FX);
    step("R4", 2, 1, 1, C_FP, C_FX, 0);
    load(1'b1, C_FX, 1'b1, C_FP);
    step("R4", 2, 1, 1, C_FX, C_FP, 0);
    load(1'b1, C_FP, 1'b1, C_FP);
    step("R4", 1, 1, 0, C_FP, 0, 0);
    load(1'b1, C_INT, 1'b1, C_FP);
    step("R8", 1, 1, 0, C_INT, 0, 0);
    load(1'b1, C_FX, 1'b1, C_INT);
    step("R8", 1, 1, 0, C_FX, 0, 0);
    load(1'b1, C_INT, 1'b0, C_INT);
    step("R8", 1, 1, 0, C_INT, 0, 0);
  endtask

  task automatic t_hazards();
    load(1'b1, C_INT, 1'b1, C_INT); s1_srca = 5'd1;
    step("R7", 1, 1, 0, C_INT, 0, 0);
    load(1'b1, C_INT, 1'b1, C_INT); s1_srcb = 5'd1;
    step("R7", 1, 1, 0, C_INT, 0, 0);
    load(1'b1, C_INT, 1'b1, C_INT); s1_dst = 5'd1;
    step("R7", 1, 1, 0, C_INT, 0, 0);
    load(1'b1, C_INT, 1'b1, C_INT); s1_srca = 5'd1; s1_dst = 5'd1; s0_wr = 1'b0;
    step("R7", 2, 1, 1, C_INT, C_INT, 0);
  endtask

  task automatic t_microcode();
    load(1'b1, C_INT, 1'b1, C_CPX);
    step("R6", 1, 1, 0, C_INT, 0, 0);
    load(1'b1, C_CPX, 1'b1, C_INT);
    step("R5", 1, 1, 0, C_CPX, 0, 1);
    load(1'b1, C_CPX, 1'b1, C_INT);
    step("R6", 0, 0, 0, 0, 0, 1);
    load(1'b1, C_INT, 1'b1, C_INT);
    step("R5", 0, 0, 0, 0, 0, 1);
    mc_done = 1'b1;
    step("R5", 0, 0, 0, 0, 0, 0);
    mc_done = 1'b0;
    step("R5", 2, 1, 1, C_INT, C_INT, 0);
  endtask

  task automatic t_blocking();
    load(1'b1, C_INT, 1'b1, C_INT); wb64_req = 1'b1;
    step("R9", 0, 0, 0, 0, 0, 0);
    wb64_req = 1'b0;
    load(1'b0, C_INT, 1'b1, C_INT);
    step("R10", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_reset_midflight();
    load(1'b1, C_CPX, 1'b0, C_INT);
    step("R5", 1, 1, 0, C_CPX, 0, 1);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R11", "mc_active cleared by reset", mc_active, 0);
    check("R11", "pipe_u_vld cleared by reset", pipe_u_vld, 0);
    rst = 1'b0;
    load(1'b1, C_INT, 1'b1, C_BR);
    step("R11", 2, 1, 1, C_INT, C_BR, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done_flag) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_int_pairs();
    t_fp_pairs();
    t_hazards();
    t_microcode();
    t_blocking();
    t_reset_midflight();
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule